// File: doc/BRIEF.md
# Serial Frame Alignment Detector

This block watches a serial bit stream, one bit per clock, and finds where each fixed-length frame begins. A frame opens with a sync word, sent most significant bit first. The sync word is 16 bits by default and the frame is 2048 bits by default. The bit clock is intended to run at 2.048 MHz. The block emits a one-clock frame marker at each boundary and an active-low lock flag that the downstream payload logic can use to gate itself. Descrambling and payload decoding sit outside this block.

While hunting, every bit position is a candidate. The first match fixes a tentative alignment. That alignment must then be confirmed at the expected position in the following frames before lock is declared. Three good sightings in a row are needed to enter lock. Once locked, only the expected position is examined. Eight consecutive bad slots are needed to leave lock. This asymmetric hysteresis keeps a noisy channel from toggling the flag, and it keeps a single corrupted word from breaking a good alignment.

Top module: `frame_sync_detector`

## Requirements
- R1: Reset puts the block in the hunting state with all counters cleared. During reset and right after it, `lock_n` is 1 and `frame_pulse` is 0. A reset applied while locked drops the lock at once.
- R2: While hunting, the sync word (MSB first on `bit_in`) is recognised when it ends at any bit offset. The frame alignment is then taken from that bit.
- R3: `lock_n` falls only on the third consecutive sighting of the sync word at expected positions spaced `FRAME_LEN` bits apart. It falls in the cycle after the edge that samples the last bit of that third word. It stays high after the first and second sightings.
- R4: During confirmation, a wrong or missing word at the expected position sends the block back to hunting, which starts from the next bit. A sync word at any other position during confirmation is ignored.
- R5: While locked, a sync word at a position other than the expected one has no effect on `lock_n` or on the frame timing.
- R6: While locked, `frame_pulse` is high for exactly one cycle every `FRAME_LEN` bits. It is high in the cycle after the edge that samples the last bit of the expected word position. This includes the slot that takes the lock and slots where the word was missed.
- R7: Up to seven consecutive bad expected slots leave the lock in place. A correct word at the expected slot clears the count of bad slots.
- R8: The eighth consecutive bad expected slot raises `lock_n` in the same cycle as that slot's `frame_pulse`. The block then hunts again from the next bit and can reacquire at a new alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one data bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| frame_pulse | output | 1 | One-cycle marker at each frame boundary while locked |
| lock_n | output | 1 | Low while frame alignment is locked, high otherwise |

## Verification
A wrong hit or miss count does not stay hidden. It shows up at `lock_n` at the very next expected slot: the lock comes one frame early or late, or the drop comes after the wrong number of bad words. A position counter that drifts or is restarted by a stray word moves `frame_pulse` off its `FRAME_LEN` spacing within one frame. The same fault usually also breaks the next confirmation. A hunt comparator that skips bit offsets leaves `lock_n` high after three well-formed frames at an odd offset.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_HELD    = 2'd2
  } fsd_state_e;

  // True when incrementing cnt would reach lim.
  function automatic logic f_hits_limit(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

  // True on the bit that closes the expected sync window.
  function automatic logic f_slot_due(input int unsigned pos, input int unsigned len);
    return pos == (len - 1);
  endfunction

endpackage

// File: rtl/fsd_window.sv
module fsd_window #(
  parameter int unsigned       SYNC_W    = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hE71A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic word_hit
);

  logic [SYNC_W-1:0] hist_q;
  logic [SYNC_W-1:0] window;

  // The newest bit forms the LSB, so the word arrives MSB first.
  assign window   = {hist_q[SYNC_W-2:0], bit_in};
  assign word_hit = (window == SYNC_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= window;
  end

endmodule

// File: rtl/fsd_slot_ctr.sv
module fsd_slot_ctr import fsd_pkg::*; #(
  parameter int unsigned FRAME_LEN = 2048,
  localparam int unsigned POS_W    = $clog2(FRAME_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic at_slot
);

  logic [POS_W-1:0] pos_q;

  assign at_slot = f_slot_due(32'(pos_q), FRAME_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pos_q <= '0;
    else if (restart | at_slot) pos_q <= '0;
    else                        pos_q <= pos_q + 1'b1;
  end

endmodule

// File: rtl/fsd_ctrl.sv
module fsd_ctrl import fsd_pkg::*; #(
  parameter int unsigned  ACQ_HITS    = 3,
  parameter int unsigned  LOSS_MISSES = 8,
  localparam int unsigned HIT_W       = $clog2(ACQ_HITS + 1),
  localparam int unsigned MISS_W      = $clog2(LOSS_MISSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_hit,
  input  logic              at_slot,
  output logic              restart,
  output logic              lock_take,
  output fsd_state_e        state,
  output logic [HIT_W-1:0]  hits,
  output logic [MISS_W-1:0] misses
);

  fsd_state_e        st_q, st_d;
  logic [HIT_W-1:0]  hits_q, hits_d;
  logic [MISS_W-1:0] miss_q, miss_d;

  always_comb begin
    st_d      = st_q;
    hits_d    = hits_q;
    miss_d    = miss_q;
    restart   = 1'b0;
    lock_take = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (word_hit) begin
          restart = 1'b1;
          miss_d  = '0;
          if (f_hits_limit(0, ACQ_HITS)) begin
            st_d      = ST_HELD;
            hits_d    = '0;
            lock_take = 1'b1;
          end else begin
            st_d   = ST_CONFIRM;
            hits_d = HIT_W'(1);
          end
        end
      end
      ST_CONFIRM: begin
        if (at_slot) begin
          if (word_hit) begin
            if (f_hits_limit(32'(hits_q), ACQ_HITS)) begin
              st_d      = ST_HELD;
              hits_d    = '0;
              lock_take = 1'b1;
            end else begin
              hits_d = hits_q + 1'b1;
            end
          end else begin
            st_d   = ST_HUNT;
            hits_d = '0;
          end
        end
      end
      ST_HELD: begin
        if (at_slot) begin
          if (word_hit) begin
            miss_d = '0;
          end else if (f_hits_limit(32'(miss_q), LOSS_MISSES)) begin
            st_d   = ST_HUNT;
            miss_d = '0;
          end else begin
            miss_d = miss_q + 1'b1;
          end
        end
      end
      default: begin
        st_d   = ST_HUNT;
        hits_d = '0;
        miss_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      hits_q <= '0;
      miss_q <= '0;
    end else begin
      st_q   <= st_d;
      hits_q <= hits_d;
      miss_q <= miss_d;
    end
  end

  assign state  = st_q;
  assign hits   = hits_q;
  assign misses = miss_q;

endmodule

// File: rtl/frame_sync_detector.sv
module frame_sync_detector import fsd_pkg::*; #(
  parameter int unsigned       SYNC_W      = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD   = 16'hE71A,
  parameter int unsigned       FRAME_LEN   = 2048,
  parameter int unsigned       ACQ_HITS    = 3,
  parameter int unsigned       LOSS_MISSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic frame_pulse,
  output logic lock_n
);

  localparam int unsigned HIT_W  = $clog2(ACQ_HITS + 1);
  localparam int unsigned MISS_W = $clog2(LOSS_MISSES + 1);

  // Internal events, named so the bound checker can see them.
  logic              word_hit;
  logic              at_slot;
  logic              restart;
  logic              lock_take;
  logic              slot_live;
  fsd_state_e        state;
  logic [HIT_W-1:0]  hits;
  logic [MISS_W-1:0] misses;
  logic              frame_q;

  fsd_window #(
    .SYNC_W    (SYNC_W),
    .SYNC_WORD (SYNC_WORD)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_in   (bit_in),
    .word_hit (word_hit)
  );

  fsd_slot_ctr #(
    .FRAME_LEN (FRAME_LEN)
  ) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .at_slot (at_slot)
  );

  fsd_ctrl #(
    .ACQ_HITS    (ACQ_HITS),
    .LOSS_MISSES (LOSS_MISSES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_hit  (word_hit),
    .at_slot   (at_slot),
    .restart   (restart),
    .lock_take (lock_take),
    .state     (state),
    .hits      (hits),
    .misses    (misses)
  );

  assign slot_live = at_slot && (state != ST_HUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b0;
    else        frame_q <= lock_take || (at_slot && (state == ST_HELD));
  end

  assign frame_pulse = frame_q;
  assign lock_n      = (state != ST_HELD);

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
  parameter int unsigned  FRAME_LEN   = 2048,
  parameter int unsigned  ACQ_HITS    = 3,
  parameter int unsigned  LOSS_MISSES = 8,
  localparam int unsigned HIT_W       = $clog2(ACQ_HITS + 1),
  localparam int unsigned MISS_W      = $clog2(LOSS_MISSES + 1),
  localparam int unsigned GAP_W       = $clog2(FRAME_LEN + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_pulse,
  input logic              lock_n,
  input logic              slot_live,
  input logic [HIT_W-1:0]  hits,
  input logic [MISS_W-1:0] misses
);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_q <= '0;
    else if (frame_pulse)          gap_q <= '0;
    else if (gap_q != {GAP_W{1'b1}}) gap_q <= gap_q + 1'b1;
  end

  AST_LOCK_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> frame_pulse); // R3

  AST_HITS_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    32'(hits) < ACQ_HITS); // R3

  AST_PULSE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (!lock_n || $rose(lock_n))); // R6

  AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && $past(!lock_n)) |-> (32'(gap_q) == FRAME_LEN - 1)); // R6

  AST_LOCK_ONLY_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_live |=> $stable(lock_n)); // R5

  AST_MISSES_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    32'(misses) < LOSS_MISSES); // R7

  AST_DROP_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_n) |-> (32'($past(misses)) == LOSS_MISSES - 1)); // R8

endmodule

bind frame_sync_detector fsd_checker #(
  .FRAME_LEN   (FRAME_LEN),
  .ACQ_HITS    (ACQ_HITS),
  .LOSS_MISSES (LOSS_MISSES)
) u_fsd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_pulse (frame_pulse),
  .lock_n      (lock_n),
  .slot_live   (slot_live),
  .hits        (hits),
  .misses      (misses)
);

// File: tb/frame_sync_detector_tb.sv
`timescale 1ns/1ps
module frame_sync_detector_tb;

  localparam int unsigned SW   = 8;
  localparam logic [SW-1:0] SYNC = 8'hB1;
  localparam logic [SW-1:0] BAD  = 8'hB0;
  localparam int unsigned FLEN = 64;
  localparam int unsigned PAY  = FLEN - SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic frame_pulse, lock_n;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  frame_sync_detector #(
    .SYNC_W (SW), .SYNC_WORD (SYNC), .FRAME_LEN (FLEN),
    .ACQ_HITS (3), .LOSS_MISSES (8)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .bit_in (bit_in),
    .frame_pulse (frame_pulse), .lock_n (lock_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    @(posedge clk);
    #5;
  endtask

  task automatic send_word(input logic [SW-1:0] w);
    for (int i = SW - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  // Payload of zeros, optionally with a sync word placed at offset ins.
  task automatic send_payload(input int ins, output int pulses, output int highs);
    pulses = 0;
    highs  = 0;
    for (int i = 0; i < int'(PAY); i++) begin
      if (ins >= 0 && i >= ins && i < ins + int'(SW)) send_bit(SYNC[SW - 1 - (i - ins)]);
      else send_bit(1'b0);
      pulses += int'(frame_pulse);
      highs  += int'(lock_n);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n  = 1'b0;
    bit_in = 1'b0;
    #1;
    chk(lock_n === 1'b1, "R1 lock_n in reset", int'(lock_n), 1);
    chk(frame_pulse === 1'b0, "R1 frame_pulse in reset", int'(frame_pulse), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Three frames from hunting, starting at a given bit offset.
  task automatic t_acquire(input int lead, input string tag);
    int p, h;
    send_zeros(lead);
    chk(lock_n === 1'b1, {tag, " unlocked before words"}, int'(lock_n), 1);
    send_word(SYNC);
    chk(lock_n === 1'b1 && frame_pulse === 1'b0, "R3 no lock after 1st word", int'(lock_n), 1);
    send_payload(-1, p, h);
    send_word(SYNC);
    chk(lock_n === 1'b1 && frame_pulse === 1'b0, "R3 no lock after 2nd word", int'(lock_n), 1);
    send_payload(-1, p, h);
    send_word(SYNC);
    chk(lock_n === 1'b0, {tag, " R3 lock on 3rd word"}, int'(lock_n), 0);
    chk(frame_pulse === 1'b1, "R6 pulse on locking slot", int'(frame_pulse), 1);
    send_payload(-1, p, h);
    chk(p == 0 && h == 0, "R6 pulse one cycle, lock held", p, 0);
  endtask

  task automatic t_locked_false_word;
    int p, h;
    send_word(SYNC);
    chk(frame_pulse === 1'b1 && lock_n === 1'b0, "R6 pulse at slot", int'(frame_pulse), 1);
    send_payload(20, p, h);
    chk(p == 0, "R5 no pulse from off-slot word", p, 0);
    chk(h == 0, "R5 lock unaffected by off-slot word", h, 0);
    send_word(SYNC);
    chk(frame_pulse === 1'b1, "R5 frame timing unchanged", int'(frame_pulse), 1);
    send_payload(-1, p, h);
  endtask

  task automatic t_misses;
    int p, h;
    int bad_run = 0;
    for (int k = 0; k < 7; k++) begin
      send_word(BAD);
      if (frame_pulse !== 1'b1 || lock_n !== 1'b0) bad_run++;
      send_payload(-1, p, h);
    end
    chk(bad_run == 0, "R7 seven misses keep lock, R6 pulses on missed slots", bad_run, 0);
    send_word(SYNC);
    chk(lock_n === 1'b0, "R7 good word after misses", int'(lock_n), 0);
    send_payload(-1, p, h);
    bad_run = 0;
    for (int k = 0; k < 7; k++) begin
      send_word(BAD);
      if (lock_n !== 1'b0) bad_run++;
      send_payload(-1, p, h);
    end
    chk(bad_run == 0, "R7 miss count cleared by good word", bad_run, 0);
    send_word(BAD);
    chk(lock_n === 1'b1, "R8 drop on 8th miss", int'(lock_n), 1);
    chk(frame_pulse === 1'b1, "R8 pulse on dropping slot", int'(frame_pulse), 1);
    send_payload(-1, p, h);
    chk(p == 0 && h == int'(PAY), "R8 hunting after drop", p, 0);
  endtask

  task automatic t_confirm_fail;
    int p, h;
    send_zeros(2);
    send_word(SYNC);
    send_payload(20, p, h);
    send_word(SYNC);
    chk(lock_n === 1'b1, "R4 still confirming", int'(lock_n), 1);
    send_payload(-1, p, h);
    send_word(BAD);
    chk(lock_n === 1'b1 && frame_pulse === 1'b0, "R4 bad slot no lock", int'(lock_n), 1);
    send_zeros(3);
    send_word(SYNC);
    send_payload(-1, p, h);
    send_word(SYNC);
    chk(lock_n === 1'b1, "R4 restarted count, 2nd word", int'(lock_n), 1);
    send_payload(-1, p, h);
    send_word(SYNC);
    chk(lock_n === 1'b0, "R4 lock after restarted search", int'(lock_n), 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int p, h;
    do_reset();
    send_payload(-1, p, h);
    chk(p == 0 && h == int'(PAY), "R1 idle after reset", h, int'(PAY));
    t_acquire(13, "R2 odd offset");
    t_locked_false_word();
    t_misses();
    t_acquire(5, "R2 reacquire R8");
    do_reset();
    chk(lock_n === 1'b1, "R1 lock dropped by reset", int'(lock_n), 1);
    t_confirm_fail();
    finish_run();
  end

endmodule